// File: doc/BRIEF.md
# Bus Master Termination Controller

This block runs the termination half of a master on a shared parallel bus with active-low control lines. A one-cycle start request opens a transaction. The block then drives the framing and initiator-ready strobes through an address phase and one or more data phases. After the address strobe it watches the target's select, ready and stop lines. When the transaction ends, it tells the rest of the master how it ended.

There are four ways a transaction can end. It can complete normally. It can end in a master abort when no target claims it in time. The target can ask for a retry before any data moved. The target can also disconnect after data has moved. Each ending produces a one-cycle report carrying a two-bit outcome code and the number of data words that completed.

The controller releases the bus strobes in a fixed order. The order depends on whether the framing strobe is still low when the ending is detected. After every transaction the block spends one idle clock before it will accept a new start. Address and data generation, arbitration and parity belong to other blocks.

Top module: `termination_ctl`

## Requirements
- R1: While reset is held, frameN and irdyN are high and termValid is low.
- R2: A startReq sampled high while idle makes frameN low with irdyN high for exactly one clock (the address phase). The first data phase follows, with irdyN low.
- R3: At each rising edge that begins a data phase (the end of the address phase, or a completed non-final transfer), lastIn is sampled. If it is high, frameN is high for that phase and irdyN stays low. irdyN is never released in the clock where frameN rises.
- R4: A transfer (devselN and trdyN low, stopN high) sampled in a phase with frameN high ends the transaction. Both strobes are high on the next clock, and termValid reports the code and the transfer count. Codes are: 0 normal, 1 master abort, 2 retry, 3 disconnect.
- R5: If devselN is high at each of the first TIMEOUT_CLKS (5) rising edges after frameN goes low, a master abort with code 1 and count 0 is reported. If devselN is low at the fifth edge, no abort occurs.
- R6: When a master abort is detected while frameN is low, the next clock shows frameN high with irdyN low, and the clock after that shows both high.
- R7: When a master abort is detected while frameN is already high, irdyN goes high on the very next clock.
- R8: stopN and devselN low with trdyN high, before any word has transferred, reports a retry (code 2) with count 0.
- R9: stopN low with devselN low reports a disconnect (code 3) if a transfer happens on that edge or any earlier one. The count includes a word transferred on the stopping edge.
- R10: On a target stop while frameN is low, the strobes go to frameN high with irdyN low for one clock, then both high. If frameN is already high, irdyN goes high on the next clock.
- R11: A startReq sampled in the first clock after irdyN goes high is ignored. One sampled on the clock after that is accepted.
- R12: Once devselN has been seen low, no abort is raised however many wait states the target inserts with trdyN and stopN high.
- R13: termValid is high for exactly one clock per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to open a transaction |
| lastIn | input | 1 | The data phase being started is the final one |
| devselN | input | 1 | Target select, active low |
| trdyN | input | 1 | Target ready, active low |
| stopN | input | 1 | Target stop, active low |
| frameN | output | 1 | Framing strobe, active low |
| irdyN | output | 1 | Initiator ready, active low |
| termValid | output | 1 | One-clock report strobe |
| termCode | output | 2 | Outcome: 0 normal, 1 abort, 2 retry, 3 disconnect |
| termCount | output | COUNT_W | Data words completed in the transaction |

## Verification
The timeout edge is probed from both sides. Select arriving exactly on the fifth edge must prevent the abort, and an off-by-one counter would raise a false abort or report one a clock late. Every ending is run once with the framing strobe still low and once with it already high, because a design that ignores this state would release irdyN too early or hold it one clock too long. The bench also separates a stop with no prior data from a stop after data, so that a retry reported as a disconnect, or a count that leaves out the word on the stopping edge, shows up in the scoreboard. A start pulse placed in the turnaround clock catches a controller that restarts with no idle gap.

// File: rtl/termctl_pkg.sv
package termctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RELEASE,
    ST_TURN
  } ctlState_t;

  typedef enum logic [1:0] {
    TERM_NORMAL     = 2'd0,
    TERM_ABORT      = 2'd1,
    TERM_RETRY      = 2'd2,
    TERM_DISCONNECT = 2'd3
  } termCode_t;

  // strobes from the control FSM to the counting datapath
  typedef struct packed {
    logic      clrCounts;
    logic      busActive;
    logic      incXfer;
    logic      capture;
    termCode_t code;
  } ctlStrobe_t;

endpackage

// File: rtl/termctl_datapath.sv
module termctl_datapath
  import termctl_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 5,
  parameter int COUNT_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic               devselN,
  output logic               abortHit,
  output logic               xferZero,
  output logic               termValid,
  output logic [1:0]         termCode,
  output logic [COUNT_W-1:0] termCount
);

  localparam int WAIT_W = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(TIMEOUT_CLKS - 1);
  localparam logic [WAIT_W-1:0] WAIT_MAX  = WAIT_W'(TIMEOUT_CLKS);

  logic [WAIT_W-1:0]  waitCnt;
  logic               devselSeen;
  logic [COUNT_W-1:0] xferCnt;
  logic [COUNT_W-1:0] xferNext;

  // select-wait counter: counts edges with no target claim
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt    <= '0;
      devselSeen <= 1'b0;
    end else if (strobe.clrCounts) begin
      waitCnt    <= '0;
      devselSeen <= 1'b0;
    end else if (strobe.busActive) begin
      if (!devselN) begin
        devselSeen <= 1'b1;
      end else if (!devselSeen && waitCnt != WAIT_MAX) begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  assign abortHit = strobe.busActive && !devselSeen && devselN && (waitCnt == WAIT_LAST);

  // transferred-word counter
  assign xferNext = xferCnt + COUNT_W'(strobe.incXfer);
  assign xferZero = (xferCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferCnt <= '0;
    end else if (strobe.clrCounts) begin
      xferCnt <= '0;
    end else begin
      xferCnt <= xferNext;
    end
  end

  // outcome report register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      termValid <= 1'b0;
      termCode  <= 2'd0;
      termCount <= '0;
    end else begin
      termValid <= strobe.capture;
      if (strobe.capture) begin
        termCode  <= strobe.code;
        termCount <= xferNext;
      end
    end
  end

endmodule

// File: rtl/termctl_control.sv
module termctl_control
  import termctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       lastIn,
  input  logic       devselN,
  input  logic       trdyN,
  input  logic       stopN,
  input  logic       abortHit,
  input  logic       xferZero,
  output ctlStrobe_t strobe,
  output logic       frameN,
  output logic       irdyN
);

  ctlState_t state, nextState;
  logic      lastPhase, nextLast;

  // where the FSM goes once the bus must be given back
  function automatic ctlState_t releaseTarget(input logic frameOff);
    return frameOff ? ST_TURN : ST_RELEASE;
  endfunction

  always_comb begin
    nextState = state;
    nextLast  = lastPhase;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          nextState        = ST_ADDR;
          nextLast         = 1'b0;
          strobe.clrCounts = 1'b1;
        end
      end
      ST_ADDR: begin
        strobe.busActive = 1'b1;
        if (abortHit) begin
          strobe.capture = 1'b1;
          strobe.code    = TERM_ABORT;
          nextState      = ST_RELEASE;
        end else begin
          nextState = ST_DATA;
          nextLast  = lastIn;
        end
      end
      ST_DATA: begin
        strobe.busActive = 1'b1;
        if (abortHit) begin
          strobe.capture = 1'b1;
          strobe.code    = TERM_ABORT;
          nextState      = releaseTarget(lastPhase);
        end else if (!devselN && !stopN) begin
          strobe.incXfer = !trdyN;
          strobe.capture = 1'b1;
          strobe.code    = (trdyN && xferZero) ? TERM_RETRY : TERM_DISCONNECT;
          nextState      = releaseTarget(lastPhase);
        end else if (!devselN && !trdyN) begin
          strobe.incXfer = 1'b1;
          if (lastPhase) begin
            strobe.capture = 1'b1;
            strobe.code    = TERM_NORMAL;
            nextState      = ST_TURN;
          end else begin
            nextLast = lastIn;
          end
        end
      end
      ST_RELEASE: nextState = ST_TURN;
      ST_TURN:    nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  // state and registered bus strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      lastPhase <= 1'b0;
      frameN    <= 1'b1;
      irdyN     <= 1'b1;
    end else begin
      state     <= nextState;
      lastPhase <= nextLast;
      frameN    <= !((nextState == ST_ADDR) || (nextState == ST_DATA && !nextLast));
      irdyN     <= !((nextState == ST_DATA) || (nextState == ST_RELEASE));
    end
  end

endmodule

// File: rtl/termination_ctl.sv
module termination_ctl
  import termctl_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 5,
  parameter int COUNT_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               lastIn,
  input  logic               devselN,
  input  logic               trdyN,
  input  logic               stopN,
  output logic               frameN,
  output logic               irdyN,
  output logic               termValid,
  output logic [1:0]         termCode,
  output logic [COUNT_W-1:0] termCount
);

  ctlStrobe_t strobe;
  logic       abortHit;
  logic       xferZero;

  termctl_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .lastIn   (lastIn),
    .devselN  (devselN),
    .trdyN    (trdyN),
    .stopN    (stopN),
    .abortHit (abortHit),
    .xferZero (xferZero),
    .strobe   (strobe),
    .frameN   (frameN),
    .irdyN    (irdyN)
  );

  termctl_datapath #(
    .TIMEOUT_CLKS (TIMEOUT_CLKS),
    .COUNT_W      (COUNT_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .devselN   (devselN),
    .abortHit  (abortHit),
    .xferZero  (xferZero),
    .termValid (termValid),
    .termCode  (termCode),
    .termCount (termCount)
  );

endmodule

// File: rtl/termctl_checker.sv
module termctl_checker #(
  parameter int COUNT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               frameN,
  input logic               irdyN,
  input logic               termValid,
  input logic [1:0]         termCode,
  input logic [COUNT_W-1:0] termCount
);

  p_addr_phase_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameN) |-> irdyN);

  p_irdy_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameN) |-> !irdyN);

  p_abort_no_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    (termValid && termCode == 2'd1) |-> (termCount == '0));

  p_retry_no_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (termValid && termCode == 2'd2) |-> (termCount == '0));

  p_frame_off_at_report_r10: assert property (@(posedge clk) disable iff (!rstN)
    termValid |-> frameN);

  p_turnaround_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irdyN) |=> frameN);

  p_single_report_r13: assert property (@(posedge clk) disable iff (!rstN)
    termValid |=> !termValid);

endmodule

bind termination_ctl termctl_checker #(.COUNT_W(COUNT_W)) u_termctl_checker (
  .clk       (clk),
  .rstN      (rstN),
  .frameN    (frameN),
  .irdyN     (irdyN),
  .termValid (termValid),
  .termCode  (termCode),
  .termCount (termCount)
);

// File: tb/termination_ctl_test.sv
module termination_ctl_test;

  localparam int COUNT_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rstN     = 1'b0;
  logic               startReq = 1'b0;
  logic               lastIn   = 1'b0;
  logic               devselN  = 1'b1;
  logic               trdyN    = 1'b1;
  logic               stopN    = 1'b1;
  logic               frameN;
  logic               irdyN;
  logic               termValid;
  logic [1:0]         termCode;
  logic [COUNT_W-1:0] termCount;

  termination_ctl #(.TIMEOUT_CLKS(5), .COUNT_W(COUNT_W)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lastIn(lastIn),
    .devselN(devselN), .trdyN(trdyN), .stopN(stopN),
    .frameN(frameN), .irdyN(irdyN), .termValid(termValid),
    .termCode(termCode), .termCount(termCount)
  );

  int nChecks = 0;
  int nFails  = 0;

  typedef struct { int code; int count; } expItem_t;
  expItem_t expQ[$];
  expItem_t got;
  logic     prevValid = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkBus(input string tag, input int f, input int i);
    chk({tag, " frameN"}, int'(frameN), f);
    chk({tag, " irdyN"}, int'(irdyN), i);
  endtask

  // set inputs at this falling edge, advance to the next one
  task automatic step(input logic dv, input logic tr, input logic st, input logic ls);
    devselN = dv; trdyN = tr; stopN = st; lastIn = ls;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic expectTerm(input int code, input int count);
    expQ.push_back('{code, count});
  endtask

  task automatic beginTxn();
    startReq = 1'b1;
    idle();
    startReq = 1'b0;
  endtask

  // scoreboard monitor: outcome codes R4 R5 R8 R9, single pulse R13
  always @(negedge clk) begin
    if (rstN) begin
      if (termValid) begin
        chk("R13 report pulse width", int'(prevValid), 0);
        if (expQ.size() == 0) begin
          nChecks++;
          nFails++;
          $display("FAIL R13 unexpected report: actual code %0d expected none", termCode);
        end else begin
          got = expQ.pop_front();
          chk("R4_R5_R8_R9 outcome code", int'(termCode), got.code);
          chk("R4_R9 transfer count", int'(termCount), got.count);
        end
      end
    end
    prevValid = termValid;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkBus("R1 reset", 1, 1);
    chk("R1 reset termValid", int'(termValid), 0);
    rstN = 1'b1;
    idle();

    // single-word normal ending, then start in turnaround clock (R2 R3 R4 R11)
    expectTerm(0, 1);
    beginTxn();
    checkBus("R2 address phase", 0, 1);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    checkBus("R3 final phase", 1, 0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    checkBus("R4 bus released", 1, 1);
    startReq = 1'b1;
    idle();
    startReq = 1'b0;
    checkBus("R11 start ignored", 1, 1);
    idle();
    checkBus("R11 still idle", 1, 1);

    // three-word burst with a wait state (R2 R3 R4 R12)
    expectTerm(0, 3);
    beginTxn();
    idle();
    checkBus("R2 first data phase", 0, 0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    checkBus("R3 not final", 0, 0);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    checkBus("R3 final after burst", 1, 0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    checkBus("R12 wait state", 1, 0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    checkBus("R4 burst released", 1, 1);
    idle();

    // abort with frame low; start right after turnaround (R5 R6 R11)
    expectTerm(1, 0);
    beginTxn();
    checkBus("R11 start accepted", 0, 1);
    repeat (4) idle();
    checkBus("R5 no early abort", 0, 0);
    idle();
    checkBus("R6 abort frame off", 1, 0);
    idle();
    checkBus("R6 abort irdy off", 1, 1);
    idle();

    // abort with frame already high (R7)
    expectTerm(1, 0);
    beginTxn();
    step(1'b1, 1'b1, 1'b1, 1'b1);
    repeat (3) idle();
    checkBus("R7 waiting final phase", 1, 0);
    idle();
    checkBus("R7 irdy released", 1, 1);
    idle();

    // retry in first phase with frame low (R8 R10)
    expectTerm(2, 0);
    beginTxn();
    idle();
    step(1'b0, 1'b1, 1'b0, 1'b0);
    checkBus("R10 stop frame off", 1, 0);
    idle();
    checkBus("R10 stop irdy off", 1, 1);
    idle();

    // retry with frame already high (R8 R10)
    expectTerm(2, 0);
    beginTxn();
    step(1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    checkBus("R10 stop in final phase", 1, 1);
    idle();

    // disconnect with data on the stopping edge (R9)
    expectTerm(3, 2);
    beginTxn();
    idle();
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    checkBus("R9 disconnect frame off", 1, 0);
    idle();
    checkBus("R9 disconnect idle", 1, 1);
    idle();

    // stop without data after one transfer (R9)
    expectTerm(3, 1);
    beginTxn();
    idle();
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    checkBus("R9 stop after data", 1, 0);
    idle();
    idle();

    // late select then long wait: no abort (R12)
    expectTerm(0, 1);
    beginTxn();
    step(1'b1, 1'b1, 1'b1, 1'b1);
    idle();
    idle();
    repeat (5) step(1'b0, 1'b1, 1'b1, 1'b0);
    checkBus("R12 no abort after select", 1, 0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    checkBus("R12 completes", 1, 1);
    idle();

    // select exactly on the fifth edge (R5 boundary)
    expectTerm(0, 1);
    beginTxn();
    step(1'b1, 1'b1, 1'b1, 1'b1);
    repeat (3) idle();
    step(1'b0, 1'b0, 1'b1, 1'b0);
    checkBus("R5 fifth-edge select", 1, 1);
    idle();
    idle();

    chk("R13 all reports delivered", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule